// File: doc/BRIEF.md
# Page-Table Address Translator

This block sits between a CPU-side request port and memory and turns virtual addresses into physical ones. A virtual address holds a virtual page number in its upper bits and a byte offset in its lower bits. The block reads a one-word table entry from memory at an address derived from a base register. When the entry is valid, it returns the entry's frame number joined to the unchanged offset. When the entry is not valid, it returns a page fault and no address. Software writes the base register on a context switch, so each process is translated through its own table.

A small fully associative cache of page-to-frame mappings sits in front of the table read. A hit answers without any memory access. A miss reads the entry, and a valid result is placed in the cache, using a free slot first and otherwise the least recently used one. A store marks the page as modified by writing the entry back with its dirty bit set. This happens only when the block cannot already see that bit set. The requester has a valid/ready handshake and one translation in flight at a time.

Top module: `xlat_unit`

## Requirements
- R1: The physical address on a valid translation is the entry's frame number in the upper PA_W-OFF_W bits, with the low OFF_W bits of the virtual address copied unchanged below it.
- R2: The table read goes to byte address base + vpn*ENTRY_BYTES, where vpn is va[VA_W-1:OFF_W]. The read is held, address steady, until mem_rvalid_i. Entry layout: bit 0 is valid, bit 1 is dirty, and bits [2 +: PA_W-OFF_W] are the frame number.
- R3: An entry with bit 0 clear produces rsp_fault_o=1 with rsp_pa_o=0 and is not cached, so repeating the same address reads memory again.
- R4: A valid entry read on a miss is inserted into the cache. A later access to the same page, with no base write in between, completes with no memory read.
- R5: Writing the base register (base_we_i=1 while idle) empties the cache. Later lookups read the new table and may yield a different frame for the same address.
- R6: A store whose page is not known to be dirty reads the entry, then writes it to the same address with bit 1 set. This holds for both a miss and a hit on a clean cached entry. A store to a page already known dirty, or a load, writes nothing. A faulting store writes nothing.
- R7: With every cache slot full, a miss on a valid entry evicts the least recently used mapping. Both hits and fills count as use. Empty slots are filled before any eviction.
- R8: req_ready_o is 1 only while idle, so it drops after a request is accepted. rsp_valid_o is a single-cycle pulse that ends each translation.
- R9: After reset the block is idle and ready, with no response, no memory read or write, and an empty cache.
- R10: With the default sizes (7-bit VA, 6-bit PA, 8-byte pages), page 0 mapped to frame 3 turns VA 0000100 into PA 011100, and an invalid entry for page 11 faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_we_i | input | 1 | Load table base register and empty the cache |
| base_i | input | MA_W | New table base byte address |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block idle and able to accept |
| req_va_i | input | VA_W | Virtual address |
| req_store_i | input | 1 | Request is a store |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_pa_o | output | PA_W | Physical address, zero on fault |
| rsp_fault_o | output | 1 | Page fault |
| mem_rd_o | output | 1 | Table entry read request, held until data |
| mem_addr_o | output | MA_W | Table entry byte address |
| mem_rdata_i | input | PTE_W | Table entry read data |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_wr_o | output | 1 | One-cycle entry write-back |
| mem_wdata_o | output | PTE_W | Entry written back with dirty bit set |

## Verification
Directed sequences first use the worked mappings of two tables. They separate the table read from the cache hit by counting memory reads per request. A base switch shows the same address landing in different frames, and a fault is repeated to show that nothing was cached. Further sequences pair a store to a clean page with a second store to the same page, which separates a write-back from its absence, and run a fill-touch-evict pattern that shows whether the least recently used slot was the one replaced. A long seeded random mix of loads, stores and base switches over partly valid tables is then compared against a bench model. The model predicts the address, fault, read count, write count and entry address for every request.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int PTE_VALID_BIT = 0;
  localparam int PTE_DIRTY_BIT = 1;
  localparam int PTE_FN_LSB    = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WALK,
    ST_WB,
    ST_RESP
  } walk_state_e;
endpackage

// File: rtl/xlat_lru.sv
module xlat_lru #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          touch_i,
  input  logic [IW-1:0] touch_idx_i,
  input  logic [N-1:0]  valid_i,
  output logic [IW-1:0] victim_o
);
  // age 0 = most recent, N-1 = least recent; ages stay a permutation
  logic [IW-1:0] age_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (flush_i) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch_i) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx_i)            age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx_i]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = '0;
    for (int i = 0; i < N; i++) begin
      if (!found && !valid_i[i]) begin
        victim_o = IW'(i);
        found    = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < N; i++)
        if (age_q[i] == IW'(N - 1)) victim_o = IW'(i);
    end
  end

  logic [N-1:0] age_seen;
  always_comb begin
    age_seen = '0;
    for (int i = 0; i < N; i++) age_seen[age_q[i]] = 1'b1;
  end

  assert_lru_perm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &age_seen);
  assert_lru_touch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i && !flush_i |=> age_q[$past(touch_idx_i)] == '0);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int N     = 4,
  parameter int VPN_W = 4,
  parameter int FN_W  = 3,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             lk_hit_o,
  output logic [IW-1:0]    lk_idx_o,
  output logic [FN_W-1:0]  lk_fn_o,
  output logic             lk_dirty_o,
  input  logic             wr_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic [FN_W-1:0]  wr_fn_i,
  input  logic             wr_dirty_i,
  output logic [N-1:0]     valid_o
);
  logic [N-1:0]     val_q;
  logic [VPN_W-1:0] vpn_q [N];
  logic [FN_W-1:0]  fn_q  [N];
  logic [N-1:0]     dirty_q;
  logic [N-1:0]     hit_vec;

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q[g]   <= 1'b0;
        vpn_q[g]   <= '0;
        fn_q[g]    <= '0;
        dirty_q[g] <= 1'b0;
      end else if (flush_i) begin
        val_q[g]   <= 1'b0;
      end else if (wr_i && wr_idx_i == IW'(g)) begin
        val_q[g]   <= 1'b1;
        vpn_q[g]   <= wr_vpn_i;
        fn_q[g]    <= wr_fn_i;
        dirty_q[g] <= wr_dirty_i;
      end
    end
    assign hit_vec[g] = val_q[g] && (vpn_q[g] == lk_vpn_i);
  end

  always_comb begin
    lk_idx_o   = '0;
    lk_fn_o    = '0;
    lk_dirty_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) begin
        lk_idx_o   = IW'(i);
        lk_fn_o    = fn_q[i];
        lk_dirty_o = dirty_q[i];
      end
    end
  end

  assign lk_hit_o = |hit_vec;
  assign valid_o  = val_q;

  assert_cache_unique_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
  assert_cache_flush_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> val_q == '0);
endmodule

// File: rtl/xlat_walk.sv
module xlat_walk
  import xlat_pkg::*;
#(
  parameter int VA_W        = 7,
  parameter int PA_W        = 6,
  parameter int OFF_W       = 3,
  parameter int MA_W        = 8,
  parameter int PTE_W       = 8,
  parameter int ENTRY_BYTES = 2,
  parameter int N           = 4,
  localparam int VPN_W      = VA_W - OFF_W,
  localparam int FN_W       = PA_W - OFF_W,
  localparam int IW         = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MA_W-1:0]  base_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_va_i,
  input  logic             req_store_i,
  output logic [VPN_W-1:0] lk_vpn_o,
  input  logic             lk_hit_i,
  input  logic [IW-1:0]    lk_idx_i,
  input  logic [FN_W-1:0]  lk_fn_i,
  input  logic             lk_dirty_i,
  input  logic [IW-1:0]    victim_i,
  output logic             touch_o,
  output logic [IW-1:0]    touch_idx_o,
  output logic             fill_o,
  output logic [IW-1:0]    fill_idx_o,
  output logic [VPN_W-1:0] fill_vpn_o,
  output logic [FN_W-1:0]  fill_fn_o,
  output logic             fill_dirty_o,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_pa_o,
  output logic             rsp_fault_o,
  output logic             mem_rd_o,
  output logic [MA_W-1:0]  mem_addr_o,
  input  logic [PTE_W-1:0] mem_rdata_i,
  input  logic             mem_rvalid_i,
  output logic             mem_wr_o,
  output logic [PTE_W-1:0] mem_wdata_o
);
  walk_state_e      state_q, state_d;
  logic [VA_W-1:0]  va_q;
  logic             store_q, hit_q, fault_q;
  logic [IW-1:0]    idx_q;
  logic [FN_W-1:0]  fn_q;
  logic [PTE_W-1:0] pte_q;
  logic             accept, pte_ok, pte_dirty;

  assign accept    = req_valid_i && (state_q == ST_IDLE);
  assign pte_ok    = mem_rdata_i[PTE_VALID_BIT];
  assign pte_dirty = mem_rdata_i[PTE_DIRTY_BIT];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)
                 state_d = (lk_hit_i && (!req_store_i || lk_dirty_i)) ? ST_RESP : ST_WALK;
      ST_WALK: if (mem_rvalid_i)
                 state_d = (pte_ok && store_q && !pte_dirty) ? ST_WB : ST_RESP;
      ST_WB:   state_d = ST_RESP;
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      store_q <= 1'b0;
      hit_q   <= 1'b0;
      fault_q <= 1'b0;
      idx_q   <= '0;
      fn_q    <= '0;
      pte_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        va_q    <= req_va_i;
        store_q <= req_store_i;
        hit_q   <= lk_hit_i;
        idx_q   <= lk_idx_i;
        fn_q    <= lk_fn_i;
        fault_q <= 1'b0;
      end
      if (state_q == ST_WALK && mem_rvalid_i) begin
        pte_q   <= mem_rdata_i;
        fault_q <= !pte_ok;
        fn_q    <= mem_rdata_i[PTE_FN_LSB +: FN_W];
      end
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign lk_vpn_o     = req_va_i[VA_W-1:OFF_W];

  assign fill_o       = (state_q == ST_WALK) && mem_rvalid_i && pte_ok;
  assign fill_idx_o   = hit_q ? idx_q : victim_i;
  assign fill_vpn_o   = va_q[VA_W-1:OFF_W];
  assign fill_fn_o    = mem_rdata_i[PTE_FN_LSB +: FN_W];
  assign fill_dirty_o = pte_dirty || store_q;

  assign touch_o      = (accept && lk_hit_i) || fill_o;
  assign touch_idx_o  = accept ? lk_idx_i : fill_idx_o;

  assign mem_rd_o     = (state_q == ST_WALK);
  assign mem_wr_o     = (state_q == ST_WB);
  assign mem_addr_o   = base_i + MA_W'(va_q[VA_W-1:OFF_W]) * MA_W'(ENTRY_BYTES);
  assign mem_wdata_o  = pte_q | PTE_W'(1 << PTE_DIRTY_BIT);

  assign rsp_valid_o  = (state_q == ST_RESP);
  assign rsp_fault_o  = rsp_valid_o && fault_q;
  assign rsp_pa_o     = (rsp_valid_o && !fault_q) ? {fn_q, va_q[OFF_W-1:0]} : '0;

  assert_rd_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o && !mem_rvalid_i |=> mem_rd_o && $stable(mem_addr_o));
  assert_wb_dirty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> mem_wdata_o[PTE_DIRTY_BIT] && mem_wdata_o[PTE_VALID_BIT]);
  assert_wb_after_rd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> $past(mem_rd_o) && $past(mem_rvalid_i));
  assert_fault_nofill_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> rsp_pa_o == '0 && !$past(fill_o));
  assert_rsp_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  assert_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit #(
  parameter int VA_W        = 7,
  parameter int PA_W        = 6,
  parameter int OFF_W       = 3,
  parameter int MA_W        = 8,
  parameter int PTE_W       = 8,
  parameter int ENTRY_BYTES = 2,
  parameter int CACHE_N     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             base_we_i,
  input  logic [MA_W-1:0]  base_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_va_i,
  input  logic             req_store_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_pa_o,
  output logic             rsp_fault_o,
  output logic             mem_rd_o,
  output logic [MA_W-1:0]  mem_addr_o,
  input  logic [PTE_W-1:0] mem_rdata_i,
  input  logic             mem_rvalid_i,
  output logic             mem_wr_o,
  output logic [PTE_W-1:0] mem_wdata_o
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int FN_W  = PA_W - OFF_W;
  localparam int IW    = (CACHE_N > 1) ? $clog2(CACHE_N) : 1;

  logic [MA_W-1:0]    base_q;
  logic [VPN_W-1:0]   lk_vpn, fill_vpn;
  logic               lk_hit, lk_dirty, touch, fill, fill_dirty;
  logic [IW-1:0]      lk_idx, victim, touch_idx, fill_idx;
  logic [FN_W-1:0]    lk_fn, fill_fn;
  logic [CACHE_N-1:0] slot_valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        base_q <= '0;
    else if (base_we_i) base_q <= base_i;
  end

  xlat_cache #(.N(CACHE_N), .VPN_W(VPN_W), .FN_W(FN_W)) u_cache (
    .clk_i, .rst_ni,
    .flush_i    (base_we_i),
    .lk_vpn_i   (lk_vpn),
    .lk_hit_o   (lk_hit),
    .lk_idx_o   (lk_idx),
    .lk_fn_o    (lk_fn),
    .lk_dirty_o (lk_dirty),
    .wr_i       (fill),
    .wr_idx_i   (fill_idx),
    .wr_vpn_i   (fill_vpn),
    .wr_fn_i    (fill_fn),
    .wr_dirty_i (fill_dirty),
    .valid_o    (slot_valid)
  );

  xlat_lru #(.N(CACHE_N)) u_lru (
    .clk_i, .rst_ni,
    .flush_i     (base_we_i),
    .touch_i     (touch),
    .touch_idx_i (touch_idx),
    .valid_i     (slot_valid),
    .victim_o    (victim)
  );

  xlat_walk #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .MA_W(MA_W),
    .PTE_W(PTE_W), .ENTRY_BYTES(ENTRY_BYTES), .N(CACHE_N)
  ) u_walk (
    .clk_i, .rst_ni,
    .base_i       (base_q),
    .req_valid_i, .req_ready_o, .req_va_i, .req_store_i,
    .lk_vpn_o     (lk_vpn),
    .lk_hit_i     (lk_hit),
    .lk_idx_i     (lk_idx),
    .lk_fn_i      (lk_fn),
    .lk_dirty_i   (lk_dirty),
    .victim_i     (victim),
    .touch_o      (touch),
    .touch_idx_o  (touch_idx),
    .fill_o       (fill),
    .fill_idx_o   (fill_idx),
    .fill_vpn_o   (fill_vpn),
    .fill_fn_o    (fill_fn),
    .fill_dirty_o (fill_dirty),
    .rsp_valid_o, .rsp_pa_o, .rsp_fault_o,
    .mem_rd_o, .mem_addr_o, .mem_rdata_i, .mem_rvalid_i,
    .mem_wr_o, .mem_wdata_o
  );

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_rd_o && !mem_wr_o && !rsp_valid_o);
endmodule

// File: tb/sim_xlat_unit.sv
module sim_xlat_unit;
  localparam int VA_W = 7, PA_W = 6, OFF_W = 3, MA_W = 8, PTE_W = 8, EB = 2, CN = 4;
  localparam int FN_W = PA_W - OFF_W;
  localparam logic [MA_W-1:0] BASE_A = 8'h00, BASE_B = 8'h40;

  logic clk_i = 0, rst_ni = 0;
  logic base_we_i = 0;
  logic [MA_W-1:0] base_i = '0;
  logic req_valid_i = 0, req_store_i = 0;
  logic [VA_W-1:0] req_va_i = '0;
  logic req_ready_o, rsp_valid_o, rsp_fault_o, mem_rd_o, mem_wr_o;
  logic [PA_W-1:0] rsp_pa_o;
  logic [MA_W-1:0] mem_addr_o;
  logic [PTE_W-1:0] mem_rdata_i = '0, mem_wdata_o;
  logic mem_rvalid_i = 0;

  always #10 clk_i = ~clk_i;

  xlat_unit u0 (.*);

  logic [PTE_W-1:0] mem [128];
  int rd_cnt = 0, wr_cnt = 0, lat = 0;
  int last_rd_addr = 0, last_wr_addr = 0;
  int n_chk = 0, n_bad = 0;
  logic [MA_W-1:0] cur_base = '0;
  logic [PA_W-1:0] last_pa;
  logic last_fault;
  int last_rds;

  // bench model of the mapping cache
  bit c_val [CN];
  int c_vpn [CN], c_fn [CN], c_stamp [CN];
  bit c_dirty [CN];
  int stamp = 0;

  function automatic logic [PA_W-1:0] make_pa(int fn, logic [VA_W-1:0] va);
    return {FN_W'(fn), va[OFF_W-1:0]};
  endfunction

  function automatic int pte_addr(logic [MA_W-1:0] b, logic [VA_W-1:0] va);
    return (int'(b) + int'(va[VA_W-1:OFF_W]) * EB) % 256;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // memory responder: two-cycle read latency, immediate writes
  initial begin
    forever begin
      @(negedge clk_i);
      if (mem_rvalid_i) mem_rvalid_i = 0;
      else if (mem_rd_o) begin
        if (lat == 1) begin
          mem_rvalid_i = 1;
          mem_rdata_i  = mem[mem_addr_o >> 1];
          rd_cnt++;
          last_rd_addr = int'(mem_addr_o);
          lat = 0;
        end else lat++;
      end
      if (mem_wr_o) begin
        mem[mem_addr_o >> 1] = mem_wdata_o;
        wr_cnt++;
        last_wr_addr = int'(mem_addr_o);
      end
    end
  end

  task automatic set_base(input logic [MA_W-1:0] b);
    @(negedge clk_i);
    base_we_i = 1; base_i = b;
    @(negedge clk_i);
    base_we_i = 0;
    cur_base = b;
    for (int i = 0; i < CN; i++) c_val[i] = 0;
  endtask

  task automatic do_req(input logic [VA_W-1:0] va, input bit st, input string tag);
    int vpn, pa_addr, slot, exp_rd, exp_wr, exp_fn, rd0, wr0, cyc;
    logic [PTE_W-1:0] pte;
    bit hit, exp_fault;
    vpn = int'(va[VA_W-1:OFF_W]);
    pa_addr = pte_addr(cur_base, va);
    pte = mem[pa_addr >> 1];
    hit = 0; slot = 0;
    for (int i = 0; i < CN; i++) if (c_val[i] && c_vpn[i] == vpn) begin hit = 1; slot = i; end
    exp_fault = 0; exp_wr = 0;
    if (hit && (!st || c_dirty[slot])) begin
      exp_rd = 0; exp_fn = c_fn[slot];
      c_stamp[slot] = ++stamp;
    end else begin
      exp_rd = 1;
      if (!pte[0]) exp_fault = 1;
      else begin
        exp_fn = int'(pte[2 +: FN_W]);
        exp_wr = (st && !pte[1]) ? 1 : 0;
        if (!hit) begin
          bit found = 0;
          int best = 0;
          for (int i = 0; i < CN; i++) if (!found && !c_val[i]) begin slot = i; found = 1; end
          if (!found) begin
            best = c_stamp[0]; slot = 0;
            for (int i = 1; i < CN; i++) if (c_stamp[i] < best) begin best = c_stamp[i]; slot = i; end
          end
        end
        c_val[slot] = 1; c_vpn[slot] = vpn; c_fn[slot] = exp_fn;
        c_dirty[slot] = pte[1] | st; c_stamp[slot] = ++stamp;
      end
    end
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk_i);
    chk(req_ready_o == 1, "R8", "ready when idle", int'(req_ready_o), 1);
    req_valid_i = 1; req_va_i = va; req_store_i = st;
    @(negedge clk_i);
    req_valid_i = 0; req_store_i = 0;
    chk(req_ready_o == 0, "R8", "ready after accept", int'(req_ready_o), 0);
    cyc = 0;
    while (!rsp_valid_o && cyc < 1000) begin @(negedge clk_i); cyc++; end
    chk(rsp_valid_o == 1, "R8", "response arrived", int'(rsp_valid_o), 1);
    last_pa = rsp_pa_o; last_fault = rsp_fault_o; last_rds = rd_cnt - rd0;
    chk(rsp_fault_o == exp_fault, exp_fault ? "R3" : tag, "fault", int'(rsp_fault_o), int'(exp_fault));
    if (exp_fault) chk(rsp_pa_o == 0, "R3", "pa on fault", int'(rsp_pa_o), 0);
    else chk(rsp_pa_o == make_pa(exp_fn, va), "R1", "pa", int'(rsp_pa_o), int'(make_pa(exp_fn, va)));
    chk(rd_cnt - rd0 == exp_rd, (exp_rd == 0) ? "R4" : tag, "reads", rd_cnt - rd0, exp_rd);
    if (exp_rd == 1) chk(last_rd_addr == pa_addr, "R2", "read addr", last_rd_addr, pa_addr);
    chk(wr_cnt - wr0 == exp_wr, "R6", "writes", wr_cnt - wr0, exp_wr);
    if (exp_wr == 1) begin
      chk(last_wr_addr == pa_addr, "R6", "write addr", last_wr_addr, pa_addr);
      chk(mem[pa_addr >> 1] == (pte | 8'h02), "R6", "written entry", int'(mem[pa_addr >> 1]), int'(pte | 8'h02));
    end
    @(negedge clk_i);
    chk(rsp_valid_o == 0, "R8", "response pulse", int'(rsp_valid_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 128; i++) begin
      logic [PTE_W-1:0] r;
      r = PTE_W'($urandom());
      mem[i] = {3'b000, r[4:2], 1'b0, ((r[7:5] != 0) ? 1'b1 : 1'b0)};
    end
    // table A (P1-like): pages 0..5 valid
    mem[0] = {3'b0, 3'd3, 2'b01}; mem[1] = {3'b0, 3'd2, 2'b01};
    mem[2] = {3'b0, 3'd6, 2'b01}; mem[3] = {3'b0, 3'd1, 2'b01};
    mem[4] = {3'b0, 3'd5, 2'b01}; mem[5] = {3'b0, 3'd4, 2'b01};
    mem[11] = {3'b0, 3'd7, 2'b01};
    // table B (P2-like)
    mem[32 + 0] = {3'b0, 3'd1, 2'b01}; mem[32 + 1] = {3'b0, 3'd4, 2'b01};
    mem[32 + 2] = {3'b0, 3'd5, 2'b01}; mem[32 + 11] = {3'b0, 3'd3, 2'b00};

    repeat (3) @(negedge clk_i);
    chk(req_ready_o == 1, "R9", "ready in reset", int'(req_ready_o), 1);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    chk(req_ready_o == 1 && rsp_valid_o == 0, "R9", "idle after reset", int'(rsp_valid_o), 0);
    chk(mem_rd_o == 0 && mem_wr_o == 0, "R9", "no memory access", int'(mem_rd_o), 0);
    chk(rd_cnt == 0 && wr_cnt == 0, "R9", "no memory traffic", rd_cnt, 0);

    set_base(BASE_A);
    do_req(7'b0000100, 0, "R10");
    chk(last_pa == 6'b011100 && last_rds == 1, "R10", "page0 frame3", int'(last_pa), 28);
    do_req(7'b0000000, 0, "R4");
    chk(last_rds == 0 && last_pa == 6'b011000, "R4", "hit no read", last_rds, 0);
    do_req(7'b0010000, 0, "R1");
    chk(last_pa == 6'b110000, "R1", "page2 frame6", int'(last_pa), 48);

    set_base(BASE_B);
    do_req(7'b0010000, 0, "R5");
    chk(last_pa == 6'b101000 && last_rds == 1, "R5", "new table frame5", int'(last_pa), 40);
    do_req(7'b0001010, 0, "R5");
    chk(last_pa == 6'b100010, "R5", "page1 frame4", int'(last_pa), 34);
    do_req(7'b1011001, 0, "R10");
    chk(last_fault == 1, "R10", "page11 fault", int'(last_fault), 1);
    do_req(7'b1011001, 1, "R3");
    chk(last_fault == 1 && last_rds == 1, "R3", "fault not cached", last_rds, 1);

    set_base(BASE_A);
    do_req(7'b1011001, 0, "R5");
    chk(last_pa == 6'b111001, "R5", "page11 frame7", int'(last_pa), 57);

    // stores: clean cached hit, then dirty cached hit
    do_req(7'b1011010, 1, "R6");
    chk(mem[11][1] == 1, "R6", "dirty bit set", int'(mem[11][1]), 1);
    do_req(7'b1011011, 1, "R6");
    do_req(7'b0011000, 1, "R6");
    chk(mem[3][1] == 1, "R6", "dirty on miss store", int'(mem[3][1]), 1);

    // LRU: fill four, touch page 0, miss page 4 evicts page 1
    set_base(BASE_A);
    do_req(7'b0000000, 0, "R7");
    do_req(7'b0001000, 0, "R7");
    do_req(7'b0010000, 0, "R7");
    do_req(7'b0011000, 0, "R7");
    do_req(7'b0000001, 0, "R7");
    chk(last_rds == 0, "R7", "touch hit", last_rds, 0);
    do_req(7'b0100000, 0, "R7");
    do_req(7'b0000010, 0, "R7");
    chk(last_rds == 0, "R7", "recent page kept", last_rds, 0);
    do_req(7'b0001001, 0, "R7");
    chk(last_rds == 1, "R7", "lru page evicted", last_rds, 1);

    for (int k = 0; k < 400; k++) begin
      if ($urandom() % 40 == 0) set_base(($urandom() % 2 == 0) ? BASE_A : BASE_B);
      do_req(VA_W'($urandom()), ($urandom() % 4) == 0, "R4");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule